// File: doc/BRIEF.md
# Serial Configuration Shift Master

This block sits on the host side of a programmable-logic target and loads a configuration stream into it over a one-wire serial path. It drives three lines: program, configuration clock and serial data. It watches two status lines from the target: an active-low init line and a done line. Configuration bytes arrive on a valid/ready stream, and a length input sampled at start says how many bytes to send.

The block runs a fixed sequence. It asserts program and waits for the target to pull init low. It keeps program asserted for a set hold time and then releases it. It waits for init to go high again, and only then shifts the bytes out, most significant bit first, one rising clock edge per bit. Before each byte it checks the target for an integrity error. After the last byte it holds the data line high and keeps clocking until done rises.

Each wait phase has its own timeout. The outcome is reported on a one-hot status vector that holds until the next start. A bulk option lets the stream fill a one-byte stage while the previous byte is still shifting; the serial waveform does not change. A read-back request is refused at once.

Top module: `sercfg_master`

## Requirements
- R1: One cycle after `start` is taken while idle, `cfg_prog` is high and `status` equals 6'b000001 (bit 0 = busy). `byte_len` and `bulk_en` are sampled at that start.
- R2: If `init_n` has not gone low within TMO_CYCLES cycles of program assertion, the run ends with `status` = 6'b000100. In the same cycle `abort_o` pulses, program is released, and no clock edge has been produced.
- R3: After `init_n` is first seen low, `cfg_prog` stays high for PROG_HOLD_CYC more cycles. No rising `cfg_clk` edge occurs before `init_n` has returned high. If it does not return high within TMO_CYCLES cycles, the run ends with `status` = 6'b001000 and an `abort_o` pulse. While `cfg_prog` is high, `cfg_clk` is low.
- R4: Bytes are sent in stream order, each as 8 bits, MSB first. The target samples `cfg_dout` on each rising edge of `cfg_clk`.
- R5: Within a byte, each bit has `cfg_clk` low for HALF_CYC cycles and then high for HALF_CYC cycles, so successive rising edges are 2*HALF_CYC cycles apart. `cfg_dout` does not change while `cfg_clk` stays high.
- R6: Before each byte, if `done_in` is low while `init_n` is low, no further bit is sent. The run ends with `status` = 6'b100000 and an `abort_o` pulse.
- R7: After the last byte, `cfg_dout` is held at 1 and `cfg_clk` keeps toggling every HALF_CYC cycles until `done_in` is seen high. The run then ends with `status` = 6'b000010, no abort, and no further clock edge.
- R8: If `done_in` stays low for TMO_CYCLES cycles of the final clocking phase, the run ends with `status` = 6'b010000 and `abort_o` does not pulse.
- R9: `status` has at most one bit set. Bit 0 is busy, bit 1 success, bit 2 init-low timeout, bit 3 init-high timeout, bit 4 done timeout, bit 5 integrity error. It is all zero after reset. When idle it holds its value until the next `start`.
- R10: `readback_req` produces a one-cycle `rb_fail` pulse in the next cycle and leaves `status` unchanged.
- R11: `s_ready` is low when not busy. With `bulk_en`=0 it is high only while the block waits at a byte boundary, so it is never high during a bit's clock-low phase once shifting has begun. With `bulk_en`=1 a one-byte stage is refilled while bits shift, and the serial output is unchanged.
- R12: With `byte_len` = 0, no data bit is shifted. The block goes straight to the final clocking phase with `cfg_dout` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| bulk_en | input | 1 | Prefetch stream bytes while shifting |
| byte_len | input | LEN_W | Number of bytes in the load |
| readback_req | input | 1 | Read-back request (always refused) |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| cfg_prog | output | 1 | Program request to target, high = asserted |
| cfg_clk | output | 1 | Configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| init_n | input | 1 | Target init line, low = asserted |
| done_in | input | 1 | Target done line |
| abort_o | output | 1 | One-cycle abort pulse on init timeout or integrity error |
| rb_fail | output | 1 | One-cycle read-back refusal |
| status | output | 6 | One-hot outcome / busy vector |

## Verification
Loads are run with contrasting byte patterns: alternating bits, runs of zeros and ones, single-bit bytes, and their complements. A swapped bit order, a dropped bit or a misordered byte therefore shows up as a different received bit string. The same kind of stream is sent once with the stall handshake and once with the prefetch stage. The bit strings must match while the handshake timing differs, which separates the two modes from the target's point of view. A bench target model is delayed, or made to stay silent, at each handshake step to reach each terminal status. It raises an integrity error after exactly two bytes, which shows that the check happens at the byte boundary and not in the middle of a byte. A zero-length load and a read-back request exercise the degenerate paths.

// File: rtl/sercfg_master.sv
module sercfg_master #(
  parameter int LEN_W         = 16,
  parameter int TMO_CYCLES    = 2_500_000,
  parameter int PROG_HOLD_CYC = 25,
  parameter int HALF_CYC      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bulk_en,
  input  logic [LEN_W-1:0] byte_len,
  input  logic             readback_req,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             cfg_prog,
  output logic             cfg_clk,
  output logic             cfg_dout,
  input  logic             init_n,
  input  logic             done_in,
  output logic             abort_o,
  output logic             rb_fail,
  output logic [5:0]       status
);

  localparam int CMAX = (TMO_CYCLES > PROG_HOLD_CYC) ? TMO_CYCLES : PROG_HOLD_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int PW   = (HALF_CYC > 1) ? $clog2(HALF_CYC + 1) : 1;

  localparam logic [5:0] ST_BUSY = 6'b000001;
  localparam logic [5:0] ST_OK   = 6'b000010;
  localparam logic [5:0] ST_TILO = 6'b000100;
  localparam logic [5:0] ST_TIHI = 6'b001000;
  localparam logic [5:0] ST_TDN  = 6'b010000;
  localparam logic [5:0] ST_CRC  = 6'b100000;

  typedef enum logic [2:0] {
    S_IDLE, S_PROG_LO, S_PROG_HOLD, S_WAIT_HI, S_FETCH, S_SHIFT, S_DONE_WAIT
  } state_t;

  state_t           st;
  logic [CW-1:0]    tcnt;
  logic [PW-1:0]    pcnt;
  logic [LEN_W-1:0] acc_left, snd_left;
  logic             bulk_q, buf_v, hi;
  logic [7:0]       buf_d, sh;
  logic [2:0]       bitn;

  wire tmo_hit  = (tcnt == CW'(TMO_CYCLES - 1));
  wire half_end = (pcnt == PW'(HALF_CYC - 1));
  wire in_load  = (st == S_WAIT_HI) || (st == S_FETCH) || (st == S_SHIFT);

  assign s_ready = !buf_v && (acc_left != '0) &&
                   (bulk_q ? in_load : (st == S_FETCH));
  wire take = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tcnt     <= '0;
      pcnt     <= '0;
      acc_left <= '0;
      snd_left <= '0;
      bulk_q   <= 1'b0;
      buf_v    <= 1'b0;
      buf_d    <= '0;
      sh       <= '0;
      bitn     <= '0;
      hi       <= 1'b0;
      cfg_prog <= 1'b0;
      cfg_clk  <= 1'b0;
      cfg_dout <= 1'b0;
      abort_o  <= 1'b0;
      rb_fail  <= 1'b0;
      status   <= '0;
    end else begin
      abort_o <= 1'b0;
      rb_fail <= readback_req;
      if (take) begin
        buf_v    <= 1'b1;
        buf_d    <= s_data;
        acc_left <= acc_left - LEN_W'(1);
      end
      case (st)
        S_IDLE: begin
          cfg_clk  <= 1'b0;
          cfg_dout <= 1'b0;
          if (start) begin
            status   <= ST_BUSY;
            cfg_prog <= 1'b1;
            tcnt     <= '0;
            acc_left <= byte_len;
            snd_left <= byte_len;
            bulk_q   <= bulk_en;
            buf_v    <= 1'b0;
            st       <= S_PROG_LO;
          end
        end
        S_PROG_LO: begin
          if (!init_n) begin
            tcnt <= '0;
            st   <= S_PROG_HOLD;
          end else if (tmo_hit) begin
            status   <= ST_TILO;
            abort_o  <= 1'b1;
            cfg_prog <= 1'b0;
            st       <= S_IDLE;
          end else begin
            tcnt <= tcnt + CW'(1);
          end
        end
        S_PROG_HOLD: begin
          if (tcnt == CW'(PROG_HOLD_CYC - 1)) begin
            cfg_prog <= 1'b0;
            tcnt     <= '0;
            st       <= S_WAIT_HI;
          end else begin
            tcnt <= tcnt + CW'(1);
          end
        end
        S_WAIT_HI: begin
          if (init_n) begin
            st <= S_FETCH;
          end else if (tmo_hit) begin
            status  <= ST_TIHI;
            abort_o <= 1'b1;
            st      <= S_IDLE;
          end else begin
            tcnt <= tcnt + CW'(1);
          end
        end
        S_FETCH: begin
          if (snd_left == '0) begin
            cfg_clk  <= 1'b0;
            cfg_dout <= 1'b1;
            tcnt     <= '0;
            pcnt     <= '0;
            st       <= S_DONE_WAIT;
          end else if (!done_in && !init_n) begin
            status  <= ST_CRC;
            abort_o <= 1'b1;
            st      <= S_IDLE;
          end else if (buf_v) begin
            buf_v    <= 1'b0;
            sh       <= buf_d;
            cfg_dout <= buf_d[7];
            cfg_clk  <= 1'b0;
            bitn     <= '0;
            pcnt     <= '0;
            hi       <= 1'b0;
            snd_left <= snd_left - LEN_W'(1);
            st       <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!half_end) begin
            pcnt <= pcnt + PW'(1);
          end else begin
            pcnt <= '0;
            if (!hi) begin
              cfg_clk <= 1'b1;
              hi      <= 1'b1;
            end else if (bitn == 3'd7) begin
              st <= S_FETCH;
            end else begin
              bitn     <= bitn + 3'd1;
              sh       <= sh << 1;
              cfg_dout <= sh[6];
              cfg_clk  <= 1'b0;
              hi       <= 1'b0;
            end
          end
        end
        S_DONE_WAIT: begin
          if (done_in) begin
            status <= ST_OK;
            st     <= S_IDLE;
          end else if (tmo_hit) begin
            status <= ST_TDN;
            st     <= S_IDLE;
          end else begin
            tcnt <= tcnt + CW'(1);
            if (half_end) begin
              pcnt    <= '0;
              cfg_clk <= ~cfg_clk;
            end else begin
              pcnt <= pcnt + PW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sercfg_master_chk.sv
module sercfg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       s_ready,
  input logic       cfg_prog,
  input logic       cfg_clk,
  input logic       cfg_dout,
  input logic       abort_o,
  input logic [5:0] status
);

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status)); // R9

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(status[0]) && !$past(start)) |-> $stable(status)); // R9

  AST_PROG_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_prog |-> status[0]); // R1

  AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_prog |-> !cfg_clk); // R3

  AST_DOUT_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_dout)); // R5

  AST_INIT_TMO_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[2]) || $rose(status[3])) |-> abort_o); // R2

  AST_CRC_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> abort_o); // R6

  AST_DONE_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !abort_o); // R8

  AST_ABORT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !status[0]); // R2

  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !s_ready); // R11

endmodule

bind sercfg_master sercfg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .s_ready(s_ready),
  .cfg_prog(cfg_prog), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout),
  .abort_o(abort_o), .status(status)
);

// File: tb/sim_sercfg_master.sv
module sim_sercfg_master;
  localparam int TMO  = 200;
  localparam int HOLD = 4;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, bulk_en = 1'b0, readback_req = 1'b0;
  logic [15:0] byte_len = '0;
  logic [7:0]  s_data = '0;
  logic        s_valid = 1'b0, s_ready;
  logic        cfg_prog, cfg_clk, cfg_dout, abort_o, rb_fail;
  logic        init_n = 1'b1, done_in = 1'b0;
  logic [5:0]  status;

  sercfg_master #(.LEN_W(16), .TMO_CYCLES(TMO), .PROG_HOLD_CYC(HOLD), .HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bulk_en(bulk_en), .byte_len(byte_len),
    .readback_req(readback_req), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .cfg_prog(cfg_prog), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .init_n(init_n),
    .done_in(done_in), .abort_o(abort_o), .rb_fail(rb_fail), .status(status));

  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;

  logic [7:0] tx_mem [0:15];
  logic       rx_bits [0:255];
  int tx_n = 0, tx_idx = 0, rx_n = 0, extra_n = 0, extra_bad = 0, abort_n = 0;
  int ncyc = 0, t_init_lo = 0, t_prog_fall = 0, rx_at_init_hi = -1;
  int lowclk_hs = 0, spacing_bad = 0, last_rise = 0;
  int m_lo = 0, m_hi = 0, m_done = 0, crc_bits = 0, lo_cnt = 0, hi_cnt = 0;
  bit hs_pend = 0, prev_prog = 0, prev_clk = 0, hi_arm = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target model and stream feeder, all driven at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      ncyc++;
      if (abort_o) abort_n++;
      if (hs_pend) tx_idx++;
      s_valid = (tx_idx < tx_n);
      s_data  = (tx_idx < tx_n) ? tx_mem[tx_idx] : 8'h00;
      hs_pend = s_valid && s_ready;
      if (hs_pend && !cfg_clk && rx_n > 0) lowclk_hs++;
      if (cfg_prog && !prev_prog) lo_cnt = 0;
      if (cfg_prog) begin
        if (m_lo >= 0 && lo_cnt == m_lo && init_n) begin
          init_n = 1'b0;
          t_init_lo = ncyc;
        end
        lo_cnt++;
      end
      if (!cfg_prog && prev_prog) begin
        t_prog_fall = ncyc;
        hi_arm = 1;
        hi_cnt = 0;
      end
      if (hi_arm) begin
        if (m_hi >= 0 && hi_cnt == m_hi) begin
          init_n = 1'b1;
          rx_at_init_hi = rx_n;
          hi_arm = 0;
        end
        hi_cnt++;
      end
      if (cfg_clk && !prev_clk) begin
        if (rx_n < tx_n * 8) begin
          rx_bits[rx_n] = cfg_dout;
          if (rx_n % 8 != 0 && ncyc - last_rise != 2 * HALF) spacing_bad++;
          last_rise = ncyc;
          rx_n++;
          if (crc_bits > 0 && rx_n == crc_bits) init_n = 1'b0;
        end else begin
          extra_n++;
          if (!cfg_dout) extra_bad++;
          if (m_done >= 0 && extra_n == m_done) done_in = 1'b1;
        end
      end
      prev_prog = cfg_prog;
      prev_clk  = cfg_clk;
    end
  end

  task automatic do_load(input int len, input bit bulk, input int lo, input int hi,
                         input int dn, input int crcb);
    m_lo = lo; m_hi = hi; m_done = dn; crc_bits = crcb;
    rx_n = 0; extra_n = 0; extra_bad = 0; abort_n = 0; lowclk_hs = 0;
    spacing_bad = 0; rx_at_init_hi = -1; hs_pend = 0; hi_arm = 0;
    t_init_lo = 0; t_prog_fall = 0;
    init_n = 1'b1; done_in = 1'b0;
    tx_n = len; tx_idx = 0; byte_len = 16'(len); bulk_en = bulk;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1;
    chk(cfg_prog === 1'b1 && status === 6'b000001, "R1 prog+busy after start",
        int'(status), 1);
    for (int w = 0; w < 5000 && status[0]; w++) @(negedge clk);
    #1;
  endtask

  task automatic chk_bits(input int len, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++)
        if (rx_bits[8*i+j] !== tx_mem[i][7-j]) bad++;
    chk(rx_n == len * 8 && bad == 0, req, bad + 1000 * rx_n, len * 8000);
  endtask

  task automatic t_reset;
    chk(status === 6'b0 && cfg_prog === 1'b0 && cfg_clk === 1'b0 && s_ready === 1'b0,
        "R9 reset state", int'(status), 0);
  endtask

  task automatic t_normal;
    tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; tx_mem[2] = 8'h01; tx_mem[3] = 8'hFE;
    do_load(4, 0, 3, 5, 5, 0);
    chk(t_prog_fall - t_init_lo == HOLD + 1, "R3 program hold", t_prog_fall - t_init_lo, HOLD + 1);
    chk(rx_at_init_hi == 0, "R3 no edge before init high", rx_at_init_hi, 0);
    chk_bits(4, "R4 MSB-first stall mode");
    chk(spacing_bad == 0, "R5 bit spacing", spacing_bad, 0);
    chk(extra_n == 5 && extra_bad == 0, "R7 trailing clocks with data high", extra_n, 5);
    chk(status === 6'b000010 && abort_n == 0, "R7 success", int'(status), 2);
    chk(lowclk_hs == 0, "R11 stall-mode ready only at byte boundary", lowclk_hs, 0);
  endtask

  task automatic t_bulk;
    tx_mem[0] = 8'h00; tx_mem[1] = 8'hFF; tx_mem[2] = 8'h81; tx_mem[3] = 8'h7E; tx_mem[4] = 8'hC3;
    do_load(5, 1, 0, 2, 3, 0);
    chk_bits(5, "R11 bulk mode bitstream");
    chk(lowclk_hs > 0, "R11 bulk refills during shift", lowclk_hs, 1);
    chk(spacing_bad == 0, "R5 bulk bit spacing", spacing_bad, 0);
    chk(status === 6'b000010, "R7 bulk success", int'(status), 2);
  endtask

  task automatic t_tmo_lo;
    do_load(2, 0, -1, 0, 1, 0);
    chk(status === 6'b000100 && abort_n == 1, "R2 init-low timeout", int'(status) + 100 * abort_n, 104);
    chk(rx_n == 0 && extra_n == 0 && cfg_prog === 1'b0, "R2 no clocking, program released", rx_n + extra_n, 0);
  endtask

  task automatic t_tmo_hi;
    do_load(2, 0, 1, -1, 1, 0);
    chk(status === 6'b001000 && abort_n == 1, "R3 init-high timeout", int'(status) + 100 * abort_n, 108);
  endtask

  task automatic t_crc;
    tx_mem[0] = 8'h5A; tx_mem[1] = 8'h96; tx_mem[2] = 8'h11; tx_mem[3] = 8'h22;
    do_load(4, 0, 1, 1, 1, 16);
    chk(status === 6'b100000 && abort_n == 1, "R6 integrity error status", int'(status) + 100 * abort_n, 132);
    chk(rx_n == 16, "R6 stopped at byte boundary", rx_n, 16);
  endtask

  task automatic t_tmo_done;
    tx_mem[0] = 8'h69;
    do_load(1, 1, 1, 1, -1, 0);
    chk(status === 6'b010000 && abort_n == 0, "R8 done timeout no abort", int'(status) + 100 * abort_n, 16);
    chk(extra_n > 0 && extra_bad == 0, "R8 clocked with data high", extra_bad, 0);
  endtask

  task automatic t_zero;
    do_load(0, 0, 2, 2, 3, 0);
    chk(rx_n == 0 && extra_n == 3 && extra_bad == 0, "R12 zero-length load", extra_n, 3);
    chk(status === 6'b000010, "R12 zero-length success", int'(status), 2);
  endtask

  task automatic t_hold_rb;
    repeat (20) @(negedge clk);
    #1;
    chk(status === 6'b000010, "R9 status held while idle", int'(status), 2);
    @(negedge clk); readback_req = 1'b1;
    @(negedge clk); readback_req = 1'b0;
    #1;
    chk(rb_fail === 1'b1 && status === 6'b000010, "R10 read-back refused", int'(rb_fail), 1);
    @(negedge clk); #1;
    chk(rb_fail === 1'b0 && status === 6'b000010, "R10 refusal is one pulse", int'(rb_fail), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_normal();
    t_bulk();
    t_tmo_lo();
    t_tmo_hi();
    t_crc();
    t_tmo_done();
    t_zero();
    t_hold_rb();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
    $finish;
  end
endmodule